// File: doc/BRIEF.md
# Ping-Pong Scratchpad Handoff Controller

This controller sits between a memory-side transfer engine (DMA) and a compute engine that share two scratchpad banks. Each bank holds everything one work unit needs. The DMA loads the next work unit into one bank while the compute engine works on the other. The controller keeps a four-valued state for every bank and tells each side which bank it should use. The compute engine never starts by itself: the controller pulses a start once a loaded bank is waiting. When the compute engine reports completion, the controller frees the bank it used and hands over the other bank.

The number of work units in a job is captured during reset. The controller then offers exactly that many fills and accepts exactly that many completions, and raises a finished flag after the last one. Two free-running counters split elapsed time into cycles spent computing and cycles the compute engine spent starved of data.

Top module: `pingpong_handoff_ctrl`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low, `job_total` is captured, every bank returns to EMPTY, both counters clear, `cmp_start` is low and both bank selects point at bank 0.
- R2: `bank_state` carries two bits per bank, bank b in bits [2b+1:2b], encoded EMPTY=0, FILLING=1, FULL=2, COMPUTING=3. `dma_ready` is high only when no fill is in progress, the bank named by `dma_bank` is EMPTY and fills remain. A `dma_fill_start` seen while `dma_ready` is low has no effect.
- R3: An accepted `dma_fill_start` moves bank `dma_bank` to FILLING on that edge. A `dma_fill_done` during a fill moves that bank to FULL and advances `dma_bank` to the other bank. A `dma_fill_done` with no fill in progress has no effect.
- R4: While the compute engine is idle, a FULL bank at `cmp_bank` produces a one-cycle `cmp_start` in the cycle after the edge that saw it FULL, and that bank becomes COMPUTING on the same edge.
- R5: If `cmp_done` is sampled while the other bank is FULL, `cmp_start` is high in the very next cycle with `cmp_bank` naming that other bank, with no idle cycle between.
- R6: An accepted `cmp_done` returns the computing bank to EMPTY. A `cmp_done` seen while nothing is computing has no effect.
- R7: Banks are filled and computed in strict alternation (0, 1, 0, ...). Work units therefore start in the order they were filled, and at most one bank is COMPUTING at any time.
- R8: `stall_cycles` rises by one on every edge where nothing is computing, completions are still owed and no bank is FULL. It is unchanged otherwise.
- R9: `busy_cycles` rises by one on every edge where a compute is in progress. It never rises on the same edge as `stall_cycles`.
- R10: After `job_total` completions, `all_done` is high and stays high. Once `job_total` fills have been accepted, `dma_ready` stays low even when a bank is EMPTY. With `job_total` of zero, `all_done` is high right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| job_total | input | CNT_W | Number of work units, captured during reset |
| dma_fill_start | input | 1 | DMA begins loading bank `dma_bank` |
| dma_fill_done | input | 1 | DMA finished loading the current bank |
| dma_ready | output | 1 | A fill may begin now |
| dma_bank | output | 1 | Bank the DMA side must load |
| cmp_done | input | 1 | Compute engine finished and is idle |
| cmp_start | output | 1 | One-cycle start for the compute engine |
| cmp_bank | output | 1 | Bank the compute engine must read |
| bank_state | output | 4 | Per-bank state, two bits per bank |
| all_done | output | 1 | Every work unit has completed |
| stall_cycles | output | CTR_W | Cycles starved of data |
| busy_cycles | output | CTR_W | Cycles spent computing |

## Verification
The bench first checks the hand-over with no gap. In that case the compute engine finishes while the other bank is already loaded, and the start must come in the next cycle. A design that waited an extra cycle, or reused the bank it had just freed, would show up as a late pulse or a wrong `cmp_bank` in the ordered queue. Next come the starved case and the counters. A fill completes while nothing is computing, so the stall count must stop exactly on the edge that saw the bank FULL. Counting off by one, or counting during compute, shifts the expected totals. Last, the bench sends a fill start while a fill is in progress, a fill done while nothing is being filled, and a completion while idle. It then checks that a bank offered for filling once all fills are used up stays unoffered. A design that accepted any of these would corrupt `bank_state`, finish early or fetch a fourth unit.

// File: rtl/pph_pkg.sv
// Shared definitions for the ping-pong handoff controller.
// Assumes a fixed pool of scratchpad banks used in round-robin order.
package pph_pkg;
    localparam int NUM_BANKS = 2;
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    typedef enum logic [1:0] {
        BK_EMPTY   = 2'd0,
        BK_FILLING = 2'd1,
        BK_FULL    = 2'd2,
        BK_BUSY    = 2'd3
    } bank_st_e;

    // Advance a bank index round-robin.
    function automatic logic [BANK_W-1:0] bank_bump(input logic [BANK_W-1:0] idx);
        return (idx == BANK_W'(NUM_BANKS - 1)) ? '0 : idx + BANK_W'(1);
    endfunction
endpackage

// File: rtl/pph_bank_fsm.sv
// One bank's ownership state: EMPTY -> FILLING -> FULL -> BUSY -> EMPTY.
// Assumes the sequencer only raises an event legal in the current state;
// any other event is held off by the state checks below.
module pph_bank_fsm
    import pph_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fill_begin,
    input  logic     fill_end,
    input  logic     run_begin,
    input  logic     run_end,
    output bank_st_e state
);
    bank_st_e state_q;
    bank_st_e state_d;

    // Next-state selection from the four lifecycle events.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_EMPTY:   if (fill_begin) state_d = BK_FILLING;
            BK_FILLING: if (fill_end)   state_d = BK_FULL;
            BK_FULL:    if (run_begin)  state_d = BK_BUSY;
            BK_BUSY:    if (run_end)    state_d = BK_EMPTY;
            default:                    state_d = BK_EMPTY;
        endcase
    end

    // State register with synchronous reset to EMPTY.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BK_EMPTY;
        else        state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/pph_sequencer.sv
// Hands banks to the DMA side and the compute side in strict rotation,
// issues the compute start pulse and tracks how much of the job is left.
// Assumes a single DMA engine (one fill in flight) and one compute engine.
module pph_sequencer
    import pph_pkg::*;
#(
    parameter int CNT_W = 16
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CNT_W-1:0]           job_total,
    input  logic                       dma_fill_start,
    input  logic                       dma_fill_done,
    input  logic                       cmp_done,
    input  bank_st_e [NUM_BANKS-1:0]   bank_st,
    output logic [NUM_BANKS-1:0]       fill_begin,
    output logic [NUM_BANKS-1:0]       fill_end,
    output logic [NUM_BANKS-1:0]       run_begin,
    output logic [NUM_BANKS-1:0]       run_end,
    output logic [BANK_W-1:0]          wr_bank,
    output logic [BANK_W-1:0]          rd_bank,
    output logic                       fill_ok,
    output logic                       start_pulse,
    output logic                       computing,
    output logic                       jobs_pending,
    output logic                       job_finished
);
    logic                 filling_q;
    logic                 computing_q;
    logic                 start_q;
    logic [BANK_W-1:0]    wptr_q;
    logic [BANK_W-1:0]    rptr_q;
    logic [CNT_W-1:0]     fills_left_q;
    logic [CNT_W-1:0]     jobs_left_q;

    logic                 fill_go;
    logic                 fill_fin;
    logic                 run_fin;
    logic                 launch;
    logic [BANK_W-1:0]    rptr_nx;

    // Accept/qualify the handshake inputs against current ownership.
    always_comb begin
        fill_ok  = !filling_q && (bank_st[wptr_q] == BK_EMPTY) && (fills_left_q != '0);
        fill_go  = dma_fill_start && fill_ok;
        fill_fin = dma_fill_done && filling_q;
        run_fin  = cmp_done && computing_q;
        rptr_nx  = run_fin ? bank_bump(rptr_q) : rptr_q;
        launch   = (!computing_q || run_fin) && (bank_st[rptr_nx] == BK_FULL);
    end

    // Route each accepted event to the bank it concerns.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_evt
        assign fill_begin[b] = fill_go  && (wptr_q  == BANK_W'(b));
        assign fill_end[b]   = fill_fin && (wptr_q  == BANK_W'(b));
        assign run_begin[b]  = launch   && (rptr_nx == BANK_W'(b));
        assign run_end[b]    = run_fin  && (rptr_q  == BANK_W'(b));
    end

    // Fill-side pointer and remaining-fill budget.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filling_q    <= 1'b0;
            wptr_q       <= '0;
            fills_left_q <= job_total;
        end else begin
            if (fill_go) begin
                filling_q    <= 1'b1;
                fills_left_q <= fills_left_q - CNT_W'(1);
            end else if (fill_fin) begin
                filling_q    <= 1'b0;
                wptr_q       <= bank_bump(wptr_q);
            end
        end
    end

    // Compute-side pointer, run flag, start pulse and completion budget.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            computing_q <= 1'b0;
            start_q     <= 1'b0;
            rptr_q      <= '0;
            jobs_left_q <= job_total;
        end else begin
            start_q <= launch;
            rptr_q  <= rptr_nx;
            if (launch)       computing_q <= 1'b1;
            else if (run_fin) computing_q <= 1'b0;
            if (run_fin)      jobs_left_q <= jobs_left_q - CNT_W'(1);
        end
    end

    assign wr_bank      = wptr_q;
    assign rd_bank      = rptr_q;
    assign start_pulse  = start_q;
    assign computing    = computing_q;
    assign jobs_pending = (jobs_left_q != '0);
    assign job_finished = (jobs_left_q == '0);
endmodule

// File: rtl/pph_perf_counters.sv
// Splits elapsed cycles into compute time and data-starved time.
// Assumes the inputs are registered state sampled at each edge.
module pph_perf_counters #(
    parameter int CTR_W = 32
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             computing,
    input  logic             jobs_pending,
    input  logic             any_full,
    output logic [CTR_W-1:0] stall_cycles,
    output logic [CTR_W-1:0] busy_cycles
);
    logic [CTR_W-1:0] stall_q;
    logic [CTR_W-1:0] busy_q;
    logic             starved;

    // Starved: engine idle, work still owed, nothing loaded to hand over.
    assign starved = !computing && jobs_pending && !any_full;

    // Two accumulators, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_q <= '0;
            busy_q  <= '0;
        end else begin
            if (starved)   stall_q <= stall_q + CTR_W'(1);
            if (computing) busy_q  <= busy_q  + CTR_W'(1);
        end
    end

    assign stall_cycles = stall_q;
    assign busy_cycles  = busy_q;
endmodule

// File: rtl/pingpong_handoff_ctrl.sv
// Top of the ping-pong scratchpad handoff controller.
// Instantiates one state machine per bank, the rotation sequencer and
// the performance counters. Assumes job_total is stable during reset.
module pingpong_handoff_ctrl
    import pph_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int CTR_W = 32
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CNT_W-1:0]       job_total,
    input  logic                   dma_fill_start,
    input  logic                   dma_fill_done,
    output logic                   dma_ready,
    output logic [BANK_W-1:0]      dma_bank,
    input  logic                   cmp_done,
    output logic                   cmp_start,
    output logic [BANK_W-1:0]      cmp_bank,
    output logic [2*NUM_BANKS-1:0] bank_state,
    output logic                   all_done,
    output logic [CTR_W-1:0]       stall_cycles,
    output logic [CTR_W-1:0]       busy_cycles
);
    bank_st_e [NUM_BANKS-1:0] bank_st;
    logic [NUM_BANKS-1:0]     fill_begin;
    logic [NUM_BANKS-1:0]     fill_end;
    logic [NUM_BANKS-1:0]     run_begin;
    logic [NUM_BANKS-1:0]     run_end;
    logic [NUM_BANKS-1:0]     full_vec;
    logic                     computing;
    logic                     jobs_pending;

    // One lifecycle state machine per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pph_bank_fsm u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .fill_begin (fill_begin[b]),
            .fill_end   (fill_end[b]),
            .run_begin  (run_begin[b]),
            .run_end    (run_end[b]),
            .state      (bank_st[b])
        );
        assign bank_state[2*b +: 2] = bank_st[b];
        assign full_vec[b]          = (bank_st[b] == BK_FULL);
    end

    pph_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .job_total      (job_total),
        .dma_fill_start (dma_fill_start),
        .dma_fill_done  (dma_fill_done),
        .cmp_done       (cmp_done),
        .bank_st        (bank_st),
        .fill_begin     (fill_begin),
        .fill_end       (fill_end),
        .run_begin      (run_begin),
        .run_end        (run_end),
        .wr_bank        (dma_bank),
        .rd_bank        (cmp_bank),
        .fill_ok        (dma_ready),
        .start_pulse    (cmp_start),
        .computing      (computing),
        .jobs_pending   (jobs_pending),
        .job_finished   (all_done)
    );

    pph_perf_counters #(.CTR_W(CTR_W)) u_perf (
        .clk          (clk),
        .rst_n        (rst_n),
        .computing    (computing),
        .jobs_pending (jobs_pending),
        .any_full     (|full_vec),
        .stall_cycles (stall_cycles),
        .busy_cycles  (busy_cycles)
    );
endmodule

// File: rtl/pph_checker.sv
// Property checker for the handoff controller, bound to the top module.
// Observes ports only.
module pph_checker
    import pph_pkg::*;
#(
    parameter int CTR_W = 32
)(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   dma_ready,
    input logic [BANK_W-1:0]      dma_bank,
    input logic                   cmp_start,
    input logic [BANK_W-1:0]      cmp_bank,
    input logic [2*NUM_BANKS-1:0] bank_state,
    input logic                   all_done,
    input logic [CTR_W-1:0]       stall_cycles,
    input logic [CTR_W-1:0]       busy_cycles
);
    // A start always names a bank that is now computing.
    p_start_on_busy_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_start |-> (bank_state[2*cmp_bank +: 2] == 2'd3));

    // Fills are only offered into an empty bank, and never after the job ends.
    p_ready_on_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dma_ready |-> ((bank_state[2*dma_bank +: 2] == 2'd0) && !all_done));

    // Finished flag is sticky.
    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        all_done |=> all_done);

    // Stall counter moves by at most one per cycle.
    p_stall_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_cycles == $past(stall_cycles)) ||
        (stall_cycles == $past(stall_cycles) + CTR_W'(1)));

    // Stall and busy time never grow on the same edge.
    p_busy_excl_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_cycles != $past(stall_cycles)) |-> (busy_cycles == $past(busy_cycles)));

    // At most one bank computing.
    p_single_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({bank_state[1:0] == 2'd3, bank_state[3:2] == 2'd3}) <= 1);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
        // A loaded bank is left only by being started.
        p_full_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(bank_state[2*b +: 2]) == 2'd2) |->
            ((bank_state[2*b +: 2] == 2'd2) || (bank_state[2*b +: 2] == 2'd3)));
        // A computing bank is left only by returning to empty.
        p_busy_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(bank_state[2*b +: 2]) == 2'd3) |->
            ((bank_state[2*b +: 2] == 2'd3) || (bank_state[2*b +: 2] == 2'd0)));
    end
endmodule

bind pingpong_handoff_ctrl pph_checker #(.CTR_W(CTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dma_ready    (dma_ready),
    .dma_bank     (dma_bank),
    .cmp_start    (cmp_start),
    .cmp_bank     (cmp_bank),
    .bank_state   (bank_state),
    .all_done     (all_done),
    .stall_cycles (stall_cycles),
    .busy_cycles  (busy_cycles)
);

// File: tb/sim_pingpong_handoff_ctrl.sv
// Scoreboard bench: the driver queues each bank as its fill completes,
// the monitor pops one entry per compute start and compares the bank.
module sim_pingpong_handoff_ctrl;
    localparam int CNT_W = 8;
    localparam int CTR_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] job_total = '0;
    logic             dma_fill_start = 1'b0;
    logic             dma_fill_done = 1'b0;
    logic             cmp_done = 1'b0;
    logic             dma_ready;
    logic             dma_bank;
    logic             cmp_start;
    logic             cmp_bank;
    logic [3:0]       bank_state;
    logic             all_done;
    logic [CTR_W-1:0] stall_cycles;
    logic [CTR_W-1:0] busy_cycles;

    int n_cmp = 0;
    int n_bad = 0;
    int n_starts = 0;
    int exp_q[$];

    always #2 clk = ~clk;

    pingpong_handoff_ctrl #(.CNT_W(CNT_W), .CTR_W(CTR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .job_total(job_total),
        .dma_fill_start(dma_fill_start), .dma_fill_done(dma_fill_done),
        .dma_ready(dma_ready), .dma_bank(dma_bank),
        .cmp_done(cmp_done), .cmp_start(cmp_start), .cmp_bank(cmp_bank),
        .bank_state(bank_state), .all_done(all_done),
        .stall_cycles(stall_cycles), .busy_cycles(busy_cycles)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic next_edge();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Monitor: each start must name the oldest filled bank (R7, R4).
    always @(negedge clk) begin
        if (rst_n && cmp_start) begin
            n_starts++;
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R7 order: actual start on bank %0d expected no start", cmp_bank);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (cmp_bank !== e[0]) begin
                    n_bad++;
                    $display("FAIL R7 order: actual bank %0d expected %0d", cmp_bank, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(4 * 20000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
        $finish;
    end

    initial begin
        // Scenario A: empty job
        rst_n = 1'b0; job_total = 8'd0;
        @(negedge clk);
        repeat (3) next_edge();
        rst_n = 1'b1;
        chk("R1 reset bank_state", bank_state, 4'b0000);
        chk("R1 reset stall", stall_cycles, 0);
        chk("R1 reset busy", busy_cycles, 0);
        chk("R1 reset cmp_start", cmp_start, 0);
        repeat (3) next_edge();
        chk("R10 zero job all_done", all_done, 1);
        chk("R10 zero job dma_ready", dma_ready, 0);
        chk("R8 zero job no stall", stall_cycles, 0);

        // Scenario B: three work units
        rst_n = 1'b0; job_total = 8'd3;
        repeat (3) next_edge();
        rst_n = 1'b1;
        chk("R1 reset dma_bank", dma_bank, 0);
        chk("R1 reset cmp_bank", cmp_bank, 0);
        chk("R2 ready after reset", dma_ready, 1);
        chk("R10 not done", all_done, 0);
        repeat (5) next_edge();                      // E1..E5
        chk("R8 stall idle", stall_cycles, 5);

        dma_fill_start = 1'b1; next_edge(); dma_fill_start = 1'b0;   // E6
        chk("R3 bank0 filling", bank_state, 4'b0001);
        chk("R2 not ready while filling", dma_ready, 0);
        next_edge(); next_edge();                    // E7, E8
        dma_fill_done = 1'b1; exp_q.push_back(0); next_edge(); dma_fill_done = 1'b0; // E9
        chk("R3 bank0 full", bank_state, 4'b0010);
        chk("R3 dma_bank advanced", dma_bank, 1);
        chk("R2 ready for bank1", dma_ready, 1);
        chk("R8 stall until full", stall_cycles, 9);
        chk("R4 no early start", cmp_start, 0);

        dma_fill_start = 1'b1; next_edge(); dma_fill_start = 1'b0;   // E10
        chk("R4 start pulse", cmp_start, 1);
        chk("R4 cmp_bank 0", cmp_bank, 0);
        chk("R4 bank0 computing bank1 filling", bank_state, 4'b0111);
        chk("R8 stall stops when full", stall_cycles, 9);

        dma_fill_start = 1'b1; next_edge(); dma_fill_start = 1'b0;   // E11 spurious
        chk("R2 start while filling ignored", bank_state, 4'b0111);
        chk("R4 single cycle start", cmp_start, 0);

        dma_fill_done = 1'b1; exp_q.push_back(1); next_edge(); dma_fill_done = 1'b0; // E12
        chk("R3 bank1 full", bank_state, 4'b1011);
        chk("R2 no ready bank0 computing", dma_ready, 0);

        dma_fill_done = 1'b1; next_edge(); dma_fill_done = 1'b0;     // E13 spurious
        chk("R3 done without fill ignored", bank_state, 4'b1011);

        cmp_done = 1'b1; next_edge(); cmp_done = 1'b0;               // E14
        chk("R5 back-to-back start", cmp_start, 1);
        chk("R5 cmp_bank 1", cmp_bank, 1);
        chk("R6 bank0 freed", bank_state, 4'b1100);
        chk("R6 bank0 offered", dma_ready, 1);
        chk("R9 busy count", busy_cycles, 4);
        chk("R8 no stall on handover", stall_cycles, 9);

        dma_fill_start = 1'b1; next_edge(); dma_fill_start = 1'b0;   // E15
        chk("R3 bank0 filling again", bank_state, 4'b1101);

        cmp_done = 1'b1; next_edge(); cmp_done = 1'b0;               // E16
        chk("R6 bank1 freed", bank_state, 4'b0001);
        chk("R10 no fill beyond total", dma_ready, 0);
        chk("R9 busy count 2", busy_cycles, 6);
        chk("R4 no start when nothing full", cmp_start, 0);

        cmp_done = 1'b1; next_edge(); cmp_done = 1'b0;               // E17 spurious
        chk("R6 idle done ignored", all_done, 0);
        chk("R8 stall resumes", stall_cycles, 10);
        next_edge();                                                 // E18
        dma_fill_done = 1'b1; exp_q.push_back(0); next_edge(); dma_fill_done = 1'b0; // E19
        chk("R8 stall while starved", stall_cycles, 12);
        chk("R3 bank0 full again", bank_state, 4'b0010);

        next_edge();                                                 // E20
        chk("R7 third start", cmp_start, 1);
        chk("R7 alternation bank0", cmp_bank, 0);
        chk("R6 idle done did not count", all_done, 0);
        next_edge();                                                 // E21
        cmp_done = 1'b1; next_edge(); cmp_done = 1'b0;               // E22
        chk("R10 all_done", all_done, 1);
        chk("R9 busy final", busy_cycles, 8);
        repeat (3) next_edge();
        chk("R10 all_done sticky", all_done, 1);
        chk("R8 no stall after job", stall_cycles, 12);
        chk("R9 busy frozen", busy_cycles, 8);
        chk("R6 all banks empty", bank_state, 4'b0000);
        chk("R7 starts seen", n_starts, 3);
        chk("R7 queue drained", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule